// File: doc/BRIEF.md
# Debug Address Comparator Bank

A bank of debug comparators that watches two address streams: the instruction fetch stream (breakpoint slots) and the data load/store stream (watchpoint slots). Each slot has a value register, which holds an aligned address, and a control register. A slot fires when it is enabled and the address word matches. The byte lane selected by the low address bits must also be marked in the slot's byte-select mask. The privilege level and the access kind of the current access must both be allowed by the slot. A breakpoint slot can also run inverted (mismatch mode). It then fires on every fetch outside its programmed location, which lets a stepping routine regain control after one instruction.

Each stream gives a registered result one cycle after the access. The result is a vector of every slot that matched, a fire flag, the index of the lowest-numbered matching slot and the address that caused the hit. Software programs the slots through an indexed register port. The write strobe takes effect at the clock edge, and the read data is combinational.

Control word layout, used by both slot kinds: bit 0 enable, bit 1 user access allowed, bit 2 privileged access allowed, bit 3 load, bit 4 store, bits 12:5 byte select (select bit k covers byte offset k), bit 13 mismatch.

Top module: `dbg_cmp_bank`

## Requirements
- R1: A slot never fires while bit 0 (enable) of its control register is clear, whatever the address.
- R2: A breakpoint compares fetch address bits above bit 1 with its value register, then fires only if byte-select bit fetch_addr[1:0] is set. A 2-byte select of 0b0011 matches offsets 0 and 1 only.
- R3: When the wide select is built (WIDE_SEL=1) and any of watchpoint select bits 7:4 is set, the watchpoint ignores address bits 2:0 in the compare and tests select bit data_addr[2:0].
- R4: Otherwise a watchpoint ignores address bits 1:0 and tests select bit data_addr[1:0]. A halfword at offset 2 (select 0b1100) fires for offsets 2 and 3 and not for offsets 0 and 1.
- R5: A watchpoint fires on a load only if bit 3 is set and on a store only if bit 4 is set. With both bits set it fires on either kind.
- R6: An access with the priv input low needs bit 1 set to fire, and an access with the priv input high needs bit 2 set.
- R7: A breakpoint with bit 13 set fires on every enabled, privilege-allowed fetch whose location does not match, and stays silent on the fetch that does match.
- R8: The hit vector shows every matching slot, and the reported slot index is the lowest-numbered one among them.
- R9: reg_kind selects the register: 0 breakpoint value, 1 breakpoint control, 2 watchpoint value, 3 watchpoint control. Value registers read back with bits 1:0 cleared. A read of an index at or beyond the slot count returns zero. A write changes matching only from the next access, not for an access sampled at the same edge.
- R10: The fire flag, slot, address and hit vector appear on the clock edge that samples the access. The fire flag and hit vector are zero after any edge that samples no valid access.
- R11: Breakpoint control words keep only bits 0–2, select bits 3:0 and bit 13. Watchpoint control words keep bits 0–4 and select bits 7:0, with bits 7:4 kept only when WIDE_SEL=1. All other bits read as zero, and breakpoints fire on fetches whatever the load/store bits written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_kind | input | 2 | Register class select |
| reg_idx | input | IDX_W | Slot index for register access |
| reg_wdata | input | ADDR_W | Write data |
| reg_rdata | output | ADDR_W | Read data (combinational) |
| fetch_valid | input | 1 | Instruction fetch present |
| fetch_addr | input | ADDR_W | Fetch address |
| fetch_priv | input | 1 | Fetch is privileged |
| data_valid | input | 1 | Data access present |
| data_addr | input | ADDR_W | Data address |
| data_store | input | 1 | 1 store, 0 load |
| data_priv | input | 1 | Data access is privileged |
| bp_fire | output | 1 | A breakpoint fired |
| bp_slot | output | BP_IW | Lowest firing breakpoint slot |
| bp_addr | output | ADDR_W | Fetch address that fired |
| bp_hits | output | NUM_BP | All matching breakpoint slots |
| wp_fire | output | 1 | A watchpoint fired |
| wp_slot | output | WP_IW | Lowest firing watchpoint slot |
| wp_addr | output | ADDR_W | Data address that fired |
| wp_hits | output | NUM_WP | All matching watchpoint slots |

## Verification
The assertions assume that the access inputs are steady around the sampling edge. They also assume that a register index beyond the slot count is only used for reads. The stimulus changes every input on the falling edge and never writes an unimplemented index. Each scenario starts by clearing every control word, so that slots left enabled by an earlier scenario cannot add hits that it did not plan for. The only exception is the deliberate overlap case.

// File: rtl/dbg_cmp_pkg.sv
package dbg_cmp_pkg;

    localparam int CTRL_W = 14;

    typedef enum logic [1:0] {
        RK_BP_VAL  = 2'd0,
        RK_BP_CTRL = 2'd1,
        RK_WP_VAL  = 2'd2,
        RK_WP_CTRL = 2'd3
    } reg_kind_e;

    typedef struct packed {
        logic       mism;
        logic [7:0] bsel;
        logic       st;
        logic       ld;
        logic       priv_en;
        logic       user_en;
        logic       en;
    } ctrl_t;

    // Keep only the fields a slot of the given kind implements.
    function automatic ctrl_t ctrl_from_word(logic [CTRL_W-1:0] w, logic is_wp, logic wide);
        ctrl_t c;
        c = ctrl_t'(w);
        if (!is_wp) begin
            c.st        = 1'b0;
            c.ld        = 1'b0;
            c.bsel[7:4] = 4'h0;
        end else begin
            c.mism = 1'b0;
            if (!wide) c.bsel[7:4] = 4'h0;
        end
        return c;
    endfunction

endpackage

// File: rtl/dbg_slot_match.sv
module dbg_slot_match
    import dbg_cmp_pkg::*;
#(
    parameter bit IS_WP    = 1'b0,
    parameter bit WIDE_SEL = 1'b1,
    parameter int ADDR_W   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic [ADDR_W-1:0] value,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_store,
    input  logic              acc_priv,
    output logic              hit
);
    logic              wide;
    logic [2:0]        off;
    logic [ADDR_W-1:0] amask;
    logic              word_eq, loc_match, priv_ok, type_ok;

    always_comb begin
        wide      = IS_WP && WIDE_SEL && (|ctrl.bsel[7:4]);
        amask     = wide ? ADDR_W'(7) : ADDR_W'(3);
        off       = wide ? acc_addr[2:0] : {1'b0, acc_addr[1:0]};
        word_eq   = ((acc_addr & ~amask) == (value & ~amask));
        loc_match = word_eq && ctrl.bsel[off];
        priv_ok   = acc_priv ? ctrl.priv_en : ctrl.user_en;
        type_ok   = IS_WP ? (acc_store ? ctrl.st : ctrl.ld) : 1'b1;
        hit       = acc_valid && ctrl.en && priv_ok && type_ok &&
                    ((!IS_WP && ctrl.mism) ? !loc_match : loc_match);
    end

    assert_disabled_silent_R1: assert property (@(posedge clk) disable iff (rst)
        !ctrl.en |-> !hit);
    assert_priv_gate_R6: assert property (@(posedge clk) disable iff (rst)
        (acc_priv ? !ctrl.priv_en : !ctrl.user_en) |-> !hit);

endmodule

// File: rtl/dbg_prio_pick.sv
module dbg_prio_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  hits,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/dbg_cmp_regs.sv
module dbg_cmp_regs
    import dbg_cmp_pkg::*;
#(
    parameter int NUM_BP   = 4,
    parameter int NUM_WP   = 4,
    parameter int ADDR_W   = 32,
    parameter int IDX_W    = 4,
    parameter bit WIDE_SEL = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        kind,
    input  logic [IDX_W-1:0]  idx,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] rdata,
    output logic [ADDR_W-1:0] bp_val [NUM_BP],
    output ctrl_t             bp_ctl [NUM_BP],
    output logic [ADDR_W-1:0] wp_val [NUM_WP],
    output ctrl_t             wp_ctl [NUM_WP]
);
    localparam int PAD_W = ADDR_W - CTRL_W;
    reg_kind_e rk;
    assign rk = reg_kind_e'(kind);

    for (genvar i = 0; i < NUM_BP; i++) begin : g_bp
        always_ff @(posedge clk) begin
            if (rst) begin
                bp_val[i] <= '0;
                bp_ctl[i] <= '0;
            end else if (wr_en && idx == IDX_W'(i)) begin
                if (rk == RK_BP_VAL)  bp_val[i] <= {wdata[ADDR_W-1:2], 2'b00};
                if (rk == RK_BP_CTRL) bp_ctl[i] <= ctrl_from_word(wdata[CTRL_W-1:0], 1'b0, WIDE_SEL);
            end
        end
    end

    for (genvar i = 0; i < NUM_WP; i++) begin : g_wp
        always_ff @(posedge clk) begin
            if (rst) begin
                wp_val[i] <= '0;
                wp_ctl[i] <= '0;
            end else if (wr_en && idx == IDX_W'(i)) begin
                if (rk == RK_WP_VAL)  wp_val[i] <= {wdata[ADDR_W-1:2], 2'b00};
                if (rk == RK_WP_CTRL) wp_ctl[i] <= ctrl_from_word(wdata[CTRL_W-1:0], 1'b1, WIDE_SEL);
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_BP; i++) begin
            if (idx == IDX_W'(i)) begin
                if (rk == RK_BP_VAL)  rdata = bp_val[i];
                if (rk == RK_BP_CTRL) rdata = {{PAD_W{1'b0}}, bp_ctl[i]};
            end
        end
        for (int i = 0; i < NUM_WP; i++) begin
            if (idx == IDX_W'(i)) begin
                if (rk == RK_WP_VAL)  rdata = wp_val[i];
                if (rk == RK_WP_CTRL) rdata = {{PAD_W{1'b0}}, wp_ctl[i]};
            end
        end
    end

    assert_unimpl_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (((rk == RK_BP_VAL || rk == RK_BP_CTRL) && idx >= IDX_W'(NUM_BP)) ||
         ((rk == RK_WP_VAL || rk == RK_WP_CTRL) && idx >= IDX_W'(NUM_WP))) |-> rdata == '0);
    assert_value_low_bits_R9: assert property (@(posedge clk) disable iff (rst)
        (rk == RK_BP_VAL || rk == RK_WP_VAL) |-> rdata[1:0] == 2'b00);

endmodule

// File: rtl/dbg_cmp_bank.sv
module dbg_cmp_bank
    import dbg_cmp_pkg::*;
#(
    parameter int NUM_BP   = 4,
    parameter int NUM_WP   = 4,
    parameter int ADDR_W   = 32,
    parameter int IDX_W    = 4,
    parameter bit WIDE_SEL = 1'b1,
    localparam int BP_IW   = (NUM_BP > 1) ? $clog2(NUM_BP) : 1,
    localparam int WP_IW   = (NUM_WP > 1) ? $clog2(NUM_WP) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_kind,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_priv,
    input  logic              data_valid,
    input  logic [ADDR_W-1:0] data_addr,
    input  logic              data_store,
    input  logic              data_priv,
    output logic              bp_fire,
    output logic [BP_IW-1:0]  bp_slot,
    output logic [ADDR_W-1:0] bp_addr,
    output logic [NUM_BP-1:0] bp_hits,
    output logic              wp_fire,
    output logic [WP_IW-1:0]  wp_slot,
    output logic [ADDR_W-1:0] wp_addr,
    output logic [NUM_WP-1:0] wp_hits
);
    logic [ADDR_W-1:0] bp_val [NUM_BP];
    ctrl_t             bp_ctl [NUM_BP];
    logic [ADDR_W-1:0] wp_val [NUM_WP];
    ctrl_t             wp_ctl [NUM_WP];
    logic [NUM_BP-1:0] bp_hit_c;
    logic [NUM_WP-1:0] wp_hit_c;
    logic              bp_any, wp_any;
    logic [BP_IW-1:0]  bp_idx_c;
    logic [WP_IW-1:0]  wp_idx_c;

    dbg_cmp_regs #(.NUM_BP(NUM_BP), .NUM_WP(NUM_WP), .ADDR_W(ADDR_W),
                   .IDX_W(IDX_W), .WIDE_SEL(WIDE_SEL)) regs_i (
        .clk(clk), .rst(rst), .wr_en(reg_wr_en), .kind(reg_kind), .idx(reg_idx),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .bp_val(bp_val), .bp_ctl(bp_ctl), .wp_val(wp_val), .wp_ctl(wp_ctl));

    for (genvar i = 0; i < NUM_BP; i++) begin : g_bp_slot
        dbg_slot_match #(.IS_WP(1'b0), .WIDE_SEL(WIDE_SEL), .ADDR_W(ADDR_W)) m_i (
            .clk(clk), .rst(rst), .ctrl(bp_ctl[i]), .value(bp_val[i]),
            .acc_valid(fetch_valid), .acc_addr(fetch_addr), .acc_store(1'b0),
            .acc_priv(fetch_priv), .hit(bp_hit_c[i]));
    end

    for (genvar i = 0; i < NUM_WP; i++) begin : g_wp_slot
        dbg_slot_match #(.IS_WP(1'b1), .WIDE_SEL(WIDE_SEL), .ADDR_W(ADDR_W)) m_i (
            .clk(clk), .rst(rst), .ctrl(wp_ctl[i]), .value(wp_val[i]),
            .acc_valid(data_valid), .acc_addr(data_addr), .acc_store(data_store),
            .acc_priv(data_priv), .hit(wp_hit_c[i]));
    end

    dbg_prio_pick #(.N(NUM_BP), .IW(BP_IW)) bp_pick_i (.hits(bp_hit_c), .any(bp_any), .idx(bp_idx_c));
    dbg_prio_pick #(.N(NUM_WP), .IW(WP_IW)) wp_pick_i (.hits(wp_hit_c), .any(wp_any), .idx(wp_idx_c));

    always_ff @(posedge clk) begin
        if (rst) begin
            bp_fire <= 1'b0; bp_slot <= '0; bp_addr <= '0; bp_hits <= '0;
            wp_fire <= 1'b0; wp_slot <= '0; wp_addr <= '0; wp_hits <= '0;
        end else begin
            bp_fire <= bp_any;
            bp_slot <= bp_idx_c;
            bp_addr <= fetch_addr;
            bp_hits <= bp_hit_c;
            wp_fire <= wp_any;
            wp_slot <= wp_idx_c;
            wp_addr <= data_addr;
            wp_hits <= wp_hit_c;
        end
    end

    assert_bp_slot_in_hits_R8: assert property (@(posedge clk) disable iff (rst)
        bp_fire |-> bp_hits[bp_slot]);
    assert_bp_slot_lowest_R8: assert property (@(posedge clk) disable iff (rst)
        bp_fire |-> ((bp_hits & ((NUM_BP'(1) << bp_slot) - NUM_BP'(1))) == '0));
    assert_wp_slot_in_hits_R8: assert property (@(posedge clk) disable iff (rst)
        wp_fire |-> wp_hits[wp_slot]);
    assert_wp_slot_lowest_R8: assert property (@(posedge clk) disable iff (rst)
        wp_fire |-> ((wp_hits & ((NUM_WP'(1) << wp_slot) - NUM_WP'(1))) == '0));
    assert_bp_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !fetch_valid |=> (bp_hits == '0 && !bp_fire));
    assert_wp_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !data_valid |=> (wp_hits == '0 && !wp_fire));
    assert_bp_addr_capture_R10: assert property (@(posedge clk) disable iff (rst)
        fetch_valid |=> bp_addr == $past(fetch_addr));

endmodule

// File: tb/dbg_cmp_bank_tb.sv
module dbg_cmp_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_kind = 2'd0;
    logic [3:0]  reg_idx = 4'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        fetch_priv = 1'b0;
    logic        data_valid = 1'b0;
    logic [31:0] data_addr = '0;
    logic        data_store = 1'b0;
    logic        data_priv = 1'b0;
    logic        bp_fire, wp_fire;
    logic [1:0]  bp_slot, wp_slot;
    logic [31:0] bp_addr, wp_addr;
    logic [3:0]  bp_hits, wp_hits;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dbg_cmp_bank dut_i (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_kind(reg_kind),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_priv(fetch_priv),
        .data_valid(data_valid), .data_addr(data_addr), .data_store(data_store),
        .data_priv(data_priv), .bp_fire(bp_fire), .bp_slot(bp_slot), .bp_addr(bp_addr),
        .bp_hits(bp_hits), .wp_fire(wp_fire), .wp_slot(wp_slot), .wp_addr(wp_addr),
        .wp_hits(wp_hits));

    // control word: en b0, user b1, priv b2, load b3, store b4, select b12:5, mismatch b13
    function automatic logic [31:0] cw(bit en, bit usr, bit prv, bit ld, bit st,
                                       logic [7:0] sel, bit mm);
        return {18'd0, mm, sel, st, ld, prv, usr, en};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] k, logic [3:0] i, logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_kind = k; reg_idx = i; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_check(string req, logic [1:0] k, logic [3:0] i, logic [31:0] exp);
        @(negedge clk);
        reg_kind = k; reg_idx = i;
        #1 check(req, reg_rdata, exp);
    endtask

    task automatic clear_all();
        for (int i = 0; i < 4; i++) begin
            wr(2'd1, 4'(i), 32'd0);
            wr(2'd3, 4'(i), 32'd0);
        end
    endtask

    task automatic fetch(string req, logic [31:0] a, bit p, bit exp_fire, int exp_slot);
        @(negedge clk);
        fetch_valid = 1'b1; fetch_addr = a; fetch_priv = p;
        @(negedge clk);
        fetch_valid = 1'b0;
        check(req, 32'(bp_fire), 32'(exp_fire));
        if (exp_fire) begin
            check(req, 32'(bp_slot), 32'(exp_slot));
            check(req, bp_addr, a);
        end
    endtask

    task automatic dacc(string req, logic [31:0] a, bit st, bit p, bit exp_fire, int exp_slot);
        @(negedge clk);
        data_valid = 1'b1; data_addr = a; data_store = st; data_priv = p;
        @(negedge clk);
        data_valid = 1'b0;
        check(req, 32'(wp_fire), 32'(exp_fire));
        if (exp_fire) begin
            check(req, 32'(wp_slot), 32'(exp_slot));
            check(req, wp_addr, a);
        end
    endtask

    task automatic t_reset();
        check("reset", 32'(bp_fire), 0);
        check("reset", 32'(wp_fire), 0);
        rd_check("reset", 2'd1, 4'd0, 32'd0);
        rd_check("reset", 2'd2, 4'd3, 32'd0);
    endtask

    task automatic t_enable_R1();
        clear_all();
        wr(2'd0, 4'd0, 32'h1000);
        wr(2'd1, 4'd0, cw(0, 1, 0, 0, 0, 8'h0F, 0));
        fetch("R1 disabled", 32'h1000, 0, 0, 0);
        wr(2'd1, 4'd0, cw(1, 1, 0, 0, 0, 8'h0F, 0));
        fetch("R1 enabled", 32'h1000, 0, 1, 0);
    endtask

    task automatic t_bp_select_R2();
        clear_all();
        wr(2'd0, 4'd1, 32'h1000);
        wr(2'd1, 4'd1, cw(1, 1, 0, 0, 0, 8'h0F, 0));
        fetch("R2 offset2 full word", 32'h1002, 0, 1, 1);
        fetch("R2 next word", 32'h1004, 0, 0, 0);
        wr(2'd1, 4'd1, cw(1, 1, 0, 0, 0, 8'h03, 0));
        fetch("R2 half0 at 0", 32'h1000, 0, 1, 1);
        fetch("R2 half0 at 2", 32'h1002, 0, 0, 0);
    endtask

    task automatic t_wp_half_R4();
        clear_all();
        wr(2'd2, 4'd0, 32'h2000);
        wr(2'd3, 4'd0, cw(1, 1, 0, 1, 1, 8'h0C, 0));
        dacc("R4 off2", 32'h2002, 0, 0, 1, 0);
        dacc("R4 off3", 32'h2003, 1, 0, 1, 0);
        dacc("R4 off1", 32'h2001, 0, 0, 0, 0);
        dacc("R4 off0", 32'h2000, 0, 0, 0, 0);
    endtask

    task automatic t_wp_wide_R3();
        clear_all();
        wr(2'd2, 4'd1, 32'h3000);
        wr(2'd3, 4'd1, cw(1, 1, 0, 1, 0, 8'hF0, 0));
        dacc("R3 upper word", 32'h3004, 0, 0, 1, 1);
        dacc("R3 lower word unselected", 32'h3000, 0, 0, 0, 0);
        dacc("R3 next dword", 32'h3008, 0, 0, 0, 0);
        wr(2'd2, 4'd1, 32'h3004);
        wr(2'd3, 4'd1, cw(1, 1, 0, 1, 0, 8'hFF, 0));
        dacc("R3 bit2 ignored", 32'h3001, 0, 0, 1, 1);
    endtask

    task automatic t_type_R5();
        clear_all();
        wr(2'd2, 4'd2, 32'h4000);
        wr(2'd3, 4'd2, cw(1, 1, 0, 1, 0, 8'h0F, 0));
        dacc("R5 load-only load", 32'h4000, 0, 0, 1, 2);
        dacc("R5 load-only store", 32'h4000, 1, 0, 0, 0);
        wr(2'd3, 4'd2, cw(1, 1, 0, 0, 1, 8'h0F, 0));
        dacc("R5 store-only store", 32'h4001, 1, 0, 1, 2);
        dacc("R5 store-only load", 32'h4001, 0, 0, 0, 0);
    endtask

    task automatic t_priv_R6();
        clear_all();
        wr(2'd0, 4'd1, 32'h5000);
        wr(2'd1, 4'd1, cw(1, 0, 1, 0, 0, 8'h0F, 0));
        fetch("R6 user blocked", 32'h5000, 0, 0, 0);
        fetch("R6 priv allowed", 32'h5000, 1, 1, 1);
        wr(2'd2, 4'd3, 32'h5100);
        wr(2'd3, 4'd3, cw(1, 1, 0, 1, 1, 8'h0F, 0));
        dacc("R6 wp priv blocked", 32'h5100, 0, 1, 0, 0);
        dacc("R6 wp user allowed", 32'h5100, 0, 0, 1, 3);
    endtask

    task automatic t_mismatch_R7();
        clear_all();
        wr(2'd0, 4'd2, 32'h6000);
        wr(2'd1, 4'd2, cw(1, 1, 0, 0, 0, 8'h0F, 1));
        fetch("R7 on location", 32'h6000, 0, 0, 0);
        fetch("R7 stepped off", 32'h6004, 0, 1, 2);
        fetch("R7 far away", 32'h0040, 0, 1, 2);
    endtask

    task automatic t_prio_R8();
        clear_all();
        wr(2'd0, 4'd0, 32'h7000);
        wr(2'd1, 4'd0, cw(1, 1, 0, 0, 0, 8'h0F, 0));
        wr(2'd0, 4'd3, 32'h7000);
        wr(2'd1, 4'd3, cw(1, 1, 0, 0, 0, 8'h0F, 0));
        wr(2'd0, 4'd2, 32'h7000);
        wr(2'd1, 4'd2, cw(1, 1, 0, 0, 0, 8'h0F, 0));
        fetch("R8 lowest of three", 32'h7000, 0, 1, 0);
        check("R8 hit vector", 32'(bp_hits), 32'h0000000D);
        wr(2'd1, 4'd0, 32'd0);
        fetch("R8 next lowest", 32'h7000, 0, 1, 2);
        check("R8 hit vector two", 32'(bp_hits), 32'h0000000C);
    endtask

    task automatic t_regs_R9();
        clear_all();
        wr(2'd0, 4'd1, 32'h8003);
        rd_check("R9 value low bits", 2'd0, 4'd1, 32'h8000);
        wr(2'd2, 4'd2, 32'h8106);
        rd_check("R9 wp value low bits", 2'd2, 4'd2, 32'h8104);
        rd_check("R9 unimplemented index", 2'd0, 4'd5, 32'd0);
        rd_check("R9 unimplemented wp index", 2'd3, 4'd9, 32'd0);
        // write enable and fetch at the same edge: old (disabled) control applies
        @(negedge clk);
        reg_wr_en = 1'b1; reg_kind = 2'd1; reg_idx = 4'd1;
        reg_wdata = cw(1, 1, 0, 0, 0, 8'h0F, 0);
        fetch_valid = 1'b1; fetch_addr = 32'h8000; fetch_priv = 1'b0;
        @(negedge clk);
        reg_wr_en = 1'b0; fetch_valid = 1'b0;
        check("R9 same-edge write not yet seen", 32'(bp_fire), 0);
        fetch("R9 write seen next access", 32'h8000, 0, 1, 1);
    endtask

    task automatic t_idle_R10();
        @(negedge clk);
        check("R10 idle fire low", 32'(bp_fire), 0);
        check("R10 idle hits zero", 32'(bp_hits), 0);
    endtask

    task automatic t_fields_R11();
        clear_all();
        wr(2'd1, 4'd0, 32'hFFFF_FFFF);
        rd_check("R11 bp ctrl fields", 2'd1, 4'd0, 32'h0000_21E7);
        wr(2'd3, 4'd0, 32'hFFFF_FFFF);
        rd_check("R11 wp ctrl fields", 2'd3, 4'd0, 32'h0000_1FFF);
        clear_all();
        wr(2'd0, 4'd3, 32'h9000);
        wr(2'd1, 4'd3, cw(1, 1, 0, 0, 0, 8'h0F, 0));
        fetch("R11 bp fires with no type bits", 32'h9000, 0, 1, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_enable_R1();
        t_bp_select_R2();
        t_wp_wide_R3();
        t_wp_half_R4();
        t_type_R5();
        t_priv_R6();
        t_mismatch_R7();
        t_prio_R8();
        t_regs_R9();
        t_idle_R10();
        t_fields_R11();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule